// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute with address generation, memory access and writeback. Each pipeline register supplies its source and destination register numbers and its write, load, store and branch flags. From these fields the unit decides, in the same cycle, where each execute operand comes from and whether a store's write data must be replaced in the memory stage. It also decides whether fetch and decode must hold while a no-op enters execute, and whether the instruction fetched behind a taken branch must be discarded.

The register file writes early in the cycle and reads late in the cycle, so a result in writeback is visible to decode without a bypass. A result that an ALU instruction produces is bypassed to the very next instruction with no lost cycle. A loaded value costs one bubble when the next instruction computes with it or forms an address from it. A loaded value that the next instruction only stores costs nothing, because it is passed straight into the store's memory-stage write data. Branches are resolved in decode, so a taken branch wastes the one instruction fetched behind it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each execute operand select `fwd_a`/`fwd_b` is 2 bits: 2'b00 takes the register file value, 2'b01 takes the writeback-stage value, 2'b10 takes the memory-stage ALU result; 2'b11 never appears.
- R2: When an execute operand is used, its source is nonzero and equals `mem_rd`, `mem_wr` is 1 and `mem_load` is 0, its select is 2'b10. A load in the memory stage is never a forwarding source for execute.
- R3: When an execute operand is used, its source is nonzero and equals `wb_rd` with `wb_wr` = 1, and R2 does not apply, its select is 2'b01; otherwise 2'b00.
- R4: When both the memory-stage ALU producer and the writeback producer write the same source register, the memory-stage (younger) producer wins with 2'b10.
- R5: A load in execute (`exe_load`=1, `exe_rd`≠0) raises `stall` when decode uses source 1 equal to `exe_rd`, or uses source 2 equal to `exe_rd` while `dec_store`=0. This covers a store whose base register (source 1) is the loaded register.
- R6: A decode store whose data register (source 2) is the loaded register does not stall for that reason. In the memory stage `st_fwd`=1 exactly when `mem_store`=1, `wb_wr`=1 and `mem_rs2`=`wb_rd`≠0.
- R7: Register 0 never produces a forwarding select other than 2'b00, never sets `st_fwd` and never causes a stall.
- R8: A branch in decode (`dec_branch`=1) raises `stall` when a used nonzero source equals `exe_rd` with `exe_wr`=1, or equals `mem_rd` with `mem_wr`=1.
- R9: `squash`=1 exactly when `dec_branch`=1, `dec_taken`=1 and `stall`=0.
- R10: A source whose use flag is 0 never forwards and never causes a stall.
- R11: `bubble` equals `stall` in every cycle, so a no-op enters execute whenever fetch and decode hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset |
| dec_src1 | input | AW | Decode source register 1 (ALU operand or address base) |
| dec_src2 | input | AW | Decode source register 2 (ALU operand or store data) |
| dec_use1 | input | 1 | Decode reads source 1 |
| dec_use2 | input | 1 | Decode reads source 2 |
| dec_store | input | 1 | Decode instruction is a store |
| dec_branch | input | 1 | Decode instruction is a branch |
| dec_taken | input | 1 | Branch resolved taken in decode |
| exe_src1 | input | AW | Execute source register 1 |
| exe_src2 | input | AW | Execute source register 2 |
| exe_use1 | input | 1 | Execute reads source 1 |
| exe_use2 | input | 1 | Execute reads source 2 |
| exe_rd | input | AW | Execute destination register |
| exe_wr | input | 1 | Execute instruction writes a register |
| exe_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_rs2 | input | AW | Memory-stage store data register |
| mem_store | input | 1 | Memory-stage instruction is a store |
| wb_rd | input | AW | Writeback destination register |
| wb_wr | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Execute operand A select |
| fwd_b | output | 2 | Execute operand B select |
| st_fwd | output | 1 | Replace store write data with the writeback value |
| stall | output | 1 | Hold PC and the fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |
| squash | output | 1 | Discard the fetch/decode register contents |

## Verification
On every cycle the embedded properties check that no select takes the unused code, that register 0 and unused sources stay inert, that the memory-stage producer wins a tie, that a store of a just-loaded value is not stalled, and that a squash never coincides with a stall. The exact mapping from every combination of register numbers and flags to selects, stall and squash can only be shown by the bench's sweeps. These sweeps cover every register pairing of a four-register configuration against every flag setting, with the expected value computed from the rules above.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic          use_src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    sel
);
  logic live;
  logic hit_mem;
  logic hit_wb;
  fwd_sel_e sel_e;

  assign live    = use_src && (src != '0);
  assign hit_mem = live && mem_wr && !mem_load && (mem_rd == src);
  assign hit_wb  = live && wb_wr && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel_e = FWD_MEM;
    else if (hit_wb) sel_e = FWD_WB;
    else             sel_e = FWD_RF;
  end
  assign sel = sel_e;

  assert_enc_R1: assert property (@(posedge clk) disable iff (rst)
    sel != 2'b11) else $error("select used reserved code");
  assert_young_R4: assert property (@(posedge clk) disable iff (rst)
    (use_src && src != '0 && mem_wr && !mem_load && mem_rd == src && wb_wr && wb_rd == src)
      |-> sel == 2'b10) else $error("older producer won");
  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> sel == 2'b00) else $error("register 0 forwarded");
  assert_unused_R10: assert property (@(posedge clk) disable iff (rst)
    !use_src |-> sel == 2'b00) else $error("unused source forwarded");
endmodule

// File: rtl/hz_ldu_detect.sv
module hz_ldu_detect #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_src1,
  input  logic [AW-1:0] dec_src2,
  input  logic          dec_use1,
  input  logic          dec_use2,
  input  logic          dec_store,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_load,
  output logic          ld_stall
);
  logic pending;
  logic addr_dep;
  logic calc_dep;

  assign pending  = exe_load && (exe_rd != '0);
  assign addr_dep = dec_use1 && (dec_src1 == exe_rd);
  assign calc_dep = dec_use2 && !dec_store && (dec_src2 == exe_rd);
  assign ld_stall = pending && (addr_dep || calc_dep);

  assert_stdata_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_store && !(dec_use1 && dec_src1 == exe_rd)) |-> !ld_stall)
    else $error("store data caused a stall");
  assert_base_R5: assert property (@(posedge clk) disable iff (rst)
    (exe_load && exe_rd != '0 && dec_store && dec_use1 && dec_src1 == exe_rd) |-> ld_stall)
    else $error("store base on loaded register not stalled");
  assert_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (exe_rd == '0) |-> !ld_stall) else $error("register 0 stalled");
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_src1,
  input  logic [AW-1:0] dec_src2,
  input  logic          dec_use1,
  input  logic          dec_use2,
  input  logic          dec_branch,
  input  logic          dec_taken,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_wr,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          ld_stall,
  output logic          br_stall,
  output logic          squash
);
  function automatic logic waits(input logic u, input logic [AW-1:0] s,
                                 input logic [AW-1:0] erd, input logic ew,
                                 input logic [AW-1:0] mrd, input logic mw);
    return u && (s != '0) && ((ew && erd == s) || (mw && mrd == s));
  endfunction

  logic dep1, dep2;
  assign dep1     = waits(dec_use1, dec_src1, exe_rd, exe_wr, mem_rd, mem_wr);
  assign dep2     = waits(dec_use2, dec_src2, exe_rd, exe_wr, mem_rd, mem_wr);
  assign br_stall = dec_branch && (dep1 || dep2);
  assign squash   = dec_branch && dec_taken && !br_stall && !ld_stall;

  assert_sq_only_taken_R9: assert property (@(posedge clk) disable iff (rst)
    squash |-> (dec_branch && dec_taken)) else $error("squash without taken branch");
  assert_sq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ld_stall || br_stall) |-> !squash) else $error("squash during stall");
  assert_nonbranch_R8: assert property (@(posedge clk) disable iff (rst)
    !dec_branch |-> !br_stall) else $error("branch stall without branch");
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dec_src1,
  input  logic [AW-1:0] dec_src2,
  input  logic          dec_use1,
  input  logic          dec_use2,
  input  logic          dec_store,
  input  logic          dec_branch,
  input  logic          dec_taken,
  input  logic [AW-1:0] exe_src1,
  input  logic [AW-1:0] exe_src2,
  input  logic          exe_use1,
  input  logic          exe_use2,
  input  logic [AW-1:0] exe_rd,
  input  logic          exe_wr,
  input  logic          exe_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [AW-1:0] mem_rs2,
  input  logic          mem_store,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd,
  output logic          stall,
  output logic          bubble,
  output logic          squash
);
  localparam int NOPS = 2;

  logic [AW-1:0] op_src [NOPS];
  logic          op_use [NOPS];
  logic [1:0]    op_sel [NOPS];
  logic          ld_stall;
  logic          br_stall;

  assign op_src[0] = exe_src1;
  assign op_src[1] = exe_src2;
  assign op_use[0] = exe_use1;
  assign op_use[1] = exe_use2;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_pick #(.AW(AW)) u_pick (
      .clk      (clk),
      .rst      (rst),
      .src      (op_src[g]),
      .use_src  (op_use[g]),
      .mem_rd   (mem_rd),
      .mem_wr   (mem_wr),
      .mem_load (mem_load),
      .wb_rd    (wb_rd),
      .wb_wr    (wb_wr),
      .sel      (op_sel[g])
    );
  end

  assign fwd_a = op_sel[0];
  assign fwd_b = op_sel[1];

  hz_ldu_detect #(.AW(AW)) u_ldu (
    .clk       (clk),
    .rst       (rst),
    .dec_src1  (dec_src1),
    .dec_src2  (dec_src2),
    .dec_use1  (dec_use1),
    .dec_use2  (dec_use2),
    .dec_store (dec_store),
    .exe_rd    (exe_rd),
    .exe_load  (exe_load),
    .ld_stall  (ld_stall)
  );

  hz_branch_ctl #(.AW(AW)) u_br (
    .clk        (clk),
    .rst        (rst),
    .dec_src1   (dec_src1),
    .dec_src2   (dec_src2),
    .dec_use1   (dec_use1),
    .dec_use2   (dec_use2),
    .dec_branch (dec_branch),
    .dec_taken  (dec_taken),
    .exe_rd     (exe_rd),
    .exe_wr     (exe_wr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ld_stall   (ld_stall),
    .br_stall   (br_stall),
    .squash     (squash)
  );

  assign st_fwd = mem_store && wb_wr && (wb_rd != '0) && (wb_rd == mem_rs2);
  assign stall  = ld_stall || br_stall;
  assign bubble = stall;

  assert_stfwd_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_rs2 == '0) |-> !st_fwd) else $error("register 0 store forward");
  assert_stfwd_store_R6: assert property (@(posedge clk) disable iff (rst)
    st_fwd |-> (mem_store && wb_wr)) else $error("store forward without store");
  assert_hold_nop_R11: assert property (@(posedge clk) disable iff (rst)
    ld_stall |-> (bubble && stall)) else $error("load stall without bubble");
endmodule

// File: tb/tb_hazard_fwd_unit.sv
module tb_hazard_fwd_unit;
  localparam int AW = 2;
  localparam int NR = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [AW-1:0] dec_src1 = '0, dec_src2 = '0, exe_src1 = '0, exe_src2 = '0;
  logic [AW-1:0] exe_rd = '0, mem_rd = '0, mem_rs2 = '0, wb_rd = '0;
  logic dec_use1 = 0, dec_use2 = 0, dec_store = 0, dec_branch = 0, dec_taken = 0;
  logic exe_use1 = 0, exe_use2 = 0, exe_wr = 0, exe_load = 0;
  logic mem_wr = 0, mem_load = 0, mem_store = 0, wb_wr = 0;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, stall, bubble, squash;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazard_fwd_unit #(.AW(AW)) dut (
    .clk(clk), .rst(rst),
    .dec_src1(dec_src1), .dec_src2(dec_src2), .dec_use1(dec_use1), .dec_use2(dec_use2),
    .dec_store(dec_store), .dec_branch(dec_branch), .dec_taken(dec_taken),
    .exe_src1(exe_src1), .exe_src2(exe_src2), .exe_use1(exe_use1), .exe_use2(exe_use2),
    .exe_rd(exe_rd), .exe_wr(exe_wr), .exe_load(exe_load),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_load(mem_load), .mem_rs2(mem_rs2),
    .mem_store(mem_store), .wb_rd(wb_rd), .wb_wr(wb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd),
    .stall(stall), .bubble(bubble), .squash(squash)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1..R4, R7, R10: expected select code from the rules
  function automatic int exp_sel(int s, int u, int mrd, int mw, int ml, int wrd, int ww);
    if (u == 0 || s == 0) return 0;
    if (mw == 1 && ml == 0 && mrd == s) return 2;
    if (ww == 1 && wrd == s) return 1;
    return 0;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset stall", int'(stall), 0);
    chk("R9 reset squash", int'(squash), 0);
    chk("R1 reset fwd_a", int'(fwd_a), 0);
    @(posedge clk);
    #1 rst = 1'b0;

    // Execute forwarding sweep: R1 R2 R3 R4 R7 R10
    for (int s = 0; s < NR; s++)
      for (int u = 0; u < 2; u++)
        for (int mrd = 0; mrd < NR; mrd++)
          for (int mw = 0; mw < 2; mw++)
            for (int ml = 0; ml < 2; ml++)
              for (int wrd = 0; wrd < NR; wrd++)
                for (int ww = 0; ww < 2; ww++) begin
                  @(posedge clk); #1;
                  exe_src1 = AW'(s); exe_src2 = AW'((s + 1) % NR);
                  exe_use1 = u[0];   exe_use2 = ~u[0];
                  mem_rd = AW'(mrd); mem_wr = mw[0]; mem_load = ml[0];
                  wb_rd = AW'(wrd);  wb_wr = ww[0];
                  @(negedge clk);
                  chk("R2/R3/R4 fwd_a", int'(fwd_a), exp_sel(s, u, mrd, mw, ml, wrd, ww));
                  chk("R2/R3/R10 fwd_b", int'(fwd_b),
                      exp_sel((s + 1) % NR, 1 - u, mrd, mw, ml, wrd, ww));
                end

    // Stall / squash sweep: R5 R6 R7 R8 R9 R10 R11
    for (int erd = 0; erd < NR; erd++)
      for (int el = 0; el < 2; el++)
        for (int ew = 0; ew < 2; ew++)
          for (int s1 = 0; s1 < NR; s1++)
            for (int s2 = 0; s2 < NR; s2++)
              for (int u1 = 0; u1 < 2; u1++)
                for (int u2 = 0; u2 < 2; u2++)
                  for (int st = 0; st < 2; st++)
                    for (int br = 0; br < 2; br++)
                      for (int tk = 0; tk < 2; tk++)
                        for (int mrd = 0; mrd < NR; mrd++)
                          for (int mw = 0; mw < 2; mw++) begin
                            int ld, bs, es;
                            @(posedge clk); #1;
                            exe_rd = AW'(erd); exe_load = el[0]; exe_wr = ew[0];
                            dec_src1 = AW'(s1); dec_src2 = AW'(s2);
                            dec_use1 = u1[0]; dec_use2 = u2[0]; dec_store = st[0];
                            dec_branch = br[0]; dec_taken = tk[0];
                            mem_rd = AW'(mrd); mem_wr = mw[0]; mem_load = 1'b0;
                            @(negedge clk);
                            ld = (el == 1 && erd != 0 &&
                                  ((u1 == 1 && s1 == erd) || (u2 == 1 && st == 0 && s2 == erd))) ? 1 : 0;
                            bs = (br == 1 &&
                                  ((u1 == 1 && s1 != 0 && ((ew == 1 && s1 == erd) || (mw == 1 && s1 == mrd))) ||
                                   (u2 == 1 && s2 != 0 && ((ew == 1 && s2 == erd) || (mw == 1 && s2 == mrd))))) ? 1 : 0;
                            es = (ld == 1 || bs == 1) ? 1 : 0;
                            chk("R5/R6/R8 stall", int'(stall), es);
                            chk("R11 bubble", int'(bubble), es);
                            chk("R9 squash", int'(squash), (br == 1 && tk == 1 && es == 0) ? 1 : 0);
                          end

    // Store data forward in memory stage: R6 R7
    for (int ms = 0; ms < 2; ms++)
      for (int r2 = 0; r2 < NR; r2++)
        for (int wrd = 0; wrd < NR; wrd++)
          for (int ww = 0; ww < 2; ww++) begin
            @(posedge clk); #1;
            mem_store = ms[0]; mem_rs2 = AW'(r2); wb_rd = AW'(wrd); wb_wr = ww[0];
            @(negedge clk);
            chk("R6 st_fwd", int'(st_fwd),
                (ms == 1 && ww == 1 && wrd != 0 && wrd == r2) ? 1 : 0);
          end

    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule